// File: doc/BRIEF.md
# Five-Source Interrupt Controller

This block arbitrates hardware interrupt requests for a small 8-bit processor. Peripherals raise one-cycle request pulses, which latch into a five-bit pending register. Software programs a five-bit enable register and can also read, set and clear the pending flags over a byte-wide memory-mapped bus. A master-enable bit, driven by the processor's enable and disable instructions, gates all dispatch.

When the master enable is set and at least one source is both pending and enabled, the controller raises a dispatch request. The request carries the jump target of the winning source, where the highest-numbered source wins. The processor accepts the request with an acknowledge. In that cycle the controller drops the winner's pending flag and the master enable, so the handler runs with interrupts off until software sets the enable again. Source 0 is wired to the vertical-blank event and source 4 to the button-change event.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset, the enable register, the pending register, the master enable, `disp_valid` and `bus_rdata` are all zero.
- R2: A bus write to address 0xFFFF stores `bus_wdata[4:0]` in the enable register. A read of 0xFFFF returns that value in bits 4:0 with bits 7:5 at zero, one cycle after the address is presented.
- R3: A bus write to address 0xFF0F replaces the pending register with `bus_wdata[4:0]`, so software can both set and clear flags. Reads of 0xFF0F return the pending bits in bits 4:0 with bits 7:5 at zero.
- R4: A high bit of `irq_pulse` sets the matching pending flag. When the pulse coincides with a bus write to 0xFF0F, the pulse wins for its own bit and the written value applies to the other bits.
- R5: `disp_valid` is high exactly when the master enable is set and the bitwise AND of the enable and pending registers is nonzero. It reflects the register state after the same clock edge.
- R6: While `disp_valid` is high, `disp_vector` equals 0x0040 + 8 × i, where i is the highest bit index set in (enable AND pending).
- R7: A cycle with `disp_valid` and `disp_ack` both high clears the selected source's pending flag and the master enable. All other pending flags are left unchanged.
- R8: `ime_set` sets the master enable and `ime_clr` clears it. When `ime_set` coincides with `ime_clr` or with an acknowledged dispatch, the master enable ends up cleared.
- R9: Bus writes to any address other than 0xFFFF and 0xFF0F change neither register. Reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| irq_pulse | input | 5 | One-cycle request pulses, one per source |
| ime_set | input | 1 | Enable-interrupts instruction strobe |
| ime_clr | input | 1 | Disable-interrupts instruction strobe |
| ime | output | 1 | Current master enable |
| disp_valid | output | 1 | Dispatch request to the processor |
| disp_vector | output | 16 | Jump target of the selected source |
| disp_ack | input | 1 | Processor accepts the dispatch |

## Verification
The bench builds the block with its default five sources, the 16-bit address bus and the 0x0040 base with a stride of 8. With these values the pair of enable and pending registers has only 1024 states, so the bench sweeps every combination. For each one it checks the request, the vector and the post-acknowledge pending value against the highest-set-bit rule. Directed cases cover the coincidences between a pulse and a flag write, and between a set and a clear or acknowledge. They also cover writes to unrelated addresses.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_FLAG = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N_SRC = 5,
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] EN_ADDR = 16'hFFFF,
  parameter logic [AW-1:0] FLAG_ADDR = 16'hFF0F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic [N_SRC-1:0] pulse,
  input  logic [N_SRC-1:0] clr_mask,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] flag_q,
  output logic [N_SRC-1:0] en_n,
  output logic [N_SRC-1:0] flag_n,
  output logic [DW-1:0]    rdata_q
);
  reg_sel_e sel;
  logic [DW-1:0] rdata_d;

  always_comb begin
    if (addr == EN_ADDR)        sel = SEL_EN;
    else if (addr == FLAG_ADDR) sel = SEL_FLAG;
    else                        sel = SEL_NONE;
  end

  always_comb begin
    en_n   = (wr && sel == SEL_EN) ? wdata[N_SRC-1:0] : en_q;
    flag_n = (((wr && sel == SEL_FLAG) ? wdata[N_SRC-1:0] : flag_q) & ~clr_mask) | pulse;
  end

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_EN:   rdata_d[N_SRC-1:0] = en_q;
      SEL_FLAG: rdata_d[N_SRC-1:0] = flag_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      flag_q  <= '0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_n;
      flag_q  <= flag_n;
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/irqc_ime.sv
module irqc_ime (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  output logic ime_q,
  output logic ime_n
);
  always_comb begin
    if (take_i || clr_i) ime_n = 1'b0;
    else if (set_i)      ime_n = 1'b1;
    else                 ime_n = ime_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ime_q <= 1'b0;
    else     ime_q <= ime_n;
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N_SRC = 5,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int N_SRC = 5,
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] EN_ADDR = 16'hFFFF,
  parameter logic [AW-1:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [AW-1:0] VEC_BASE = 16'h0040,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N_SRC-1:0] irq_pulse,
  input  logic             ime_set,
  input  logic             ime_clr,
  output logic             ime,
  output logic             disp_valid,
  output logic [AW-1:0]    disp_vector,
  input  logic             disp_ack
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] en_q, flag_q, en_n, flag_n, clr_mask;
  logic             ime_n, take, sel_any;
  logic [IDX_W-1:0] sel_idx, idx_q;

  assign take = disp_valid & disp_ack;

  for (genvar g = 0; g < N_SRC; g++) begin : g_clr
    assign clr_mask[g] = take && (idx_q == IDX_W'(g));
  end

  irqc_regs #(
    .N_SRC(N_SRC), .AW(AW), .DW(DW),
    .EN_ADDR(EN_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .pulse(irq_pulse), .clr_mask(clr_mask),
    .en_q(en_q), .flag_q(flag_q), .en_n(en_n), .flag_n(flag_n),
    .rdata_q(bus_rdata)
  );

  irqc_ime u_ime (
    .clk(clk), .rst(rst), .set_i(ime_set), .clr_i(ime_clr), .take_i(take),
    .ime_q(ime), .ime_n(ime_n)
  );

  irqc_prio #(.N_SRC(N_SRC)) u_prio (
    .req(en_n & flag_n), .any(sel_any), .idx(sel_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid  <= 1'b0;
      disp_vector <= VEC_BASE;
      idx_q       <= '0;
    end else begin
      disp_valid  <= ime_n & sel_any;
      disp_vector <= VEC_BASE + AW'(sel_idx) * AW'(VEC_STRIDE);
      idx_q       <= sel_idx;
    end
  end
endmodule

// File: rtl/irqc_sva.sv
module irqc_sva #(
  parameter int N_SRC = 5,
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] VEC_BASE = 16'h0040,
  parameter int VEC_STRIDE = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] irq_pulse,
  input logic             ime_set,
  input logic             ime_clr,
  input logic             ime,
  input logic             disp_valid,
  input logic [AW-1:0]    disp_vector,
  input logic             disp_ack,
  input logic [N_SRC-1:0] flag_q,
  input logic [DW-1:0]    bus_rdata
);
  localparam logic [AW-1:0] VMAX = VEC_BASE + AW'(N_SRC - 1) * AW'(VEC_STRIDE);

  a_r5_valid_needs_ime: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> ime);

  a_r7_ack_drops_ime: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ack) |=> !ime);

  a_r8_set_raises_ime: assert property (@(posedge clk) disable iff (rst)
    (ime_set && !ime_clr && !(disp_valid && disp_ack)) |=> ime);

  a_r8_clr_wins: assert property (@(posedge clk) disable iff (rst)
    ime_clr |=> !ime);

  a_r4_pulse_latches: assert property (@(posedge clk) disable iff (rst)
    (|irq_pulse) |=> ((flag_q & $past(irq_pulse)) == $past(irq_pulse)));

  a_r6_vector_in_range: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> (disp_vector >= VEC_BASE && disp_vector <= VMAX));

  a_r2_upper_read_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DW-1:N_SRC] == '0);
endmodule

bind irqc_top irqc_sva #(
  .N_SRC(N_SRC), .AW(AW), .DW(DW), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_sva (
  .clk(clk), .rst(rst), .irq_pulse(irq_pulse), .ime_set(ime_set),
  .ime_clr(ime_clr), .ime(ime), .disp_valid(disp_valid),
  .disp_vector(disp_vector), .disp_ack(disp_ack), .flag_q(flag_q),
  .bus_rdata(bus_rdata)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [4:0]  irq_pulse = 5'd0;
  logic        ime_set = 1'b0, ime_clr = 1'b0, ime, disp_valid, disp_ack = 1'b0;
  logic [15:0] disp_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse),
    .ime_set(ime_set), .ime_clr(ime_clr), .ime(ime), .disp_valid(disp_valid),
    .disp_vector(disp_vector), .disp_ack(disp_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    tick();
    d = bus_rdata;
  endtask

  function automatic int top_bit(input logic [4:0] v);
    int r = -1;
    for (int i = 0; i < 5; i++) if (v[i]) r = i;
    return r;
  endfunction

  initial begin
    logic [7:0] d;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 ime", ime, 0);
    chk("R1 valid", disp_valid, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(16'hFFFF, d); chk("R1 enable", d, 0);
    rd(16'hFF0F, d); chk("R1 pending", d, 0);

    // R2 / R3 masking
    wr(16'hFFFF, 8'hFF); rd(16'hFFFF, d); chk("R2 enable masked", d, 8'h1F);
    wr(16'hFF0F, 8'hEA); rd(16'hFF0F, d); chk("R3 pending masked", d, 8'h0A);
    wr(16'hFF0F, 8'h00); rd(16'hFF0F, d); chk("R3 pending cleared", d, 8'h00);

    // R9 other addresses
    wr(16'hFF00, 8'hFF); wr(16'hFFFE, 8'h00); wr(16'hFF0E, 8'h1F);
    rd(16'hFFFF, d); chk("R9 enable untouched", d, 8'h1F);
    rd(16'hFF0F, d); chk("R9 pending untouched", d, 8'h00);
    rd(16'hFF00, d); chk("R9 read other zero", d, 8'h00);

    // R4 pulse sets, beats a write for its own bit
    irq_pulse = 5'b00001; tick(); irq_pulse = 5'd0;
    rd(16'hFF0F, d); chk("R4 pulse latches", d, 8'h01);
    bus_addr = 16'hFF0F; bus_wdata = 8'h12; bus_wr = 1'b1; irq_pulse = 5'b00100;
    tick(); bus_wr = 1'b0; irq_pulse = 5'd0;
    rd(16'hFF0F, d); chk("R4 pulse with write", d, 8'h16);
    bus_wdata = 8'h00; bus_wr = 1'b1; irq_pulse = 5'b10000;
    tick(); bus_wr = 1'b0; irq_pulse = 5'd0;
    rd(16'hFF0F, d); chk("R4 pulse beats clear", d, 8'h10);

    // R5 no dispatch without master enable
    chk("R5 no ime no valid", disp_valid, 0);

    // R8 set/clear interplay
    ime_set = 1'b1; ime_clr = 1'b1; tick(); ime_set = 1'b0; ime_clr = 1'b0;
    chk("R8 clear beats set", ime, 0);
    ime_set = 1'b1; tick(); ime_set = 1'b0;
    chk("R8 set", ime, 1);
    chk("R5 valid same edge", disp_valid, 1);
    chk("R6 vector bit4", disp_vector, 16'h0060);
    disp_ack = 1'b1; ime_set = 1'b1; tick(); disp_ack = 1'b0; ime_set = 1'b0;
    chk("R8 ack beats set", ime, 0);
    chk("R7 valid drops", disp_valid, 0);
    rd(16'hFF0F, d); chk("R7 flag cleared", d, 8'h00);
    ime_clr = 1'b1; tick(); ime_clr = 1'b0;
    chk("R8 clear", ime, 0);

    // Exhaustive sweep over enable x pending
    for (int e = 0; e < 32; e++) begin
      for (int f = 0; f < 32; f++) begin
        int hb;
        logic [4:0] m;
        hb = top_bit(5'(e) & 5'(f));
        wr(16'hFFFF, 8'(e));
        wr(16'hFF0F, 8'(f));
        chk("R5 no valid while ime off", disp_valid, 0);
        ime_set = 1'b1; tick(); ime_set = 1'b0;
        chk("R5 valid rule", disp_valid, (hb >= 0) ? 1 : 0);
        if (hb >= 0) begin
          chk("R6 vector", disp_vector, 32'h40 + 32'(8 * hb));
          disp_ack = 1'b1; tick(); disp_ack = 1'b0;
          chk("R7 ime dropped", ime, 0);
          m = 5'(f) & ~(5'd1 << hb);
          rd(16'hFF0F, d); chk("R7 only winner cleared", d, {3'b000, m});
        end else begin
          ime_clr = 1'b1; tick(); ime_clr = 1'b0;
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule